// File: doc/BRIEF.md
# Stream-to-Memory Write Master

This block takes 32-bit words from a valid/ready streaming sink and writes them to a memory-mapped slave at consecutive word addresses. A FIFO whose depth is a power of two sits between the stream input and the memory port. A command consists of a start pulse, a byte start address and a length in words. While a transfer runs, the block issues one write per word held in the FIFO. It keeps each write steady while the slave stalls, and it gives a one-cycle done pulse once the programmed number of words has been accepted.

The sink accepts words from the moment reset is released, whether or not a command is pending. Any words that collect before a command are therefore the first ones written by the next transfer, and they count toward its length. Software that wants to discard such stale words pulses the flush input while the block is idle. The FIFO fill level is reported as a counter of log2(depth) bits that wraps to zero at exactly depth words, together with a separate full flag. The true level is depth when the flag is set and the counter value otherwise.

Top module: `stm_wr_master`

## Requirements
- R1: After reset, snk_ready is 1, busy is 0, done is 0, mem_write is 0, fill_cnt is 0 and fill_full is 0. Words offered while idle with snk_valid high are stored, and fill_cnt counts them.
- R2: snk_ready is low exactly while the FIFO holds DEPTH words. A word offered while snk_ready is low is not stored and is never written to memory.
- R3: When the FIFO holds DEPTH words, fill_cnt reads 0 and fill_full reads 1. The first pop after that leaves fill_cnt at DEPTH-1 with fill_full at 0.
- R4: In a cycle where a word is both pushed and popped, fill_cnt and fill_full stay unchanged.
- R5: Words are written in strict arrival order. Words stored before the start pulse are written first and count toward the length.
- R6: The first write of a transfer goes to cmd_addr. Each write accepted by the slave advances mem_addr by 4. mem_be is always 4'hF.
- R7: While mem_write and mem_waitreq are both high, mem_write, mem_addr and mem_wdata hold their values into the next cycle.
- R8: mem_write is never high while busy is low. A FIFO word is removed only by a write the slave accepts.
- R9: done is high for exactly one cycle, in the cycle after the last accepted write, and busy is low in that same cycle. A start with a length of 0 gives done in the next cycle and no write.
- R10: A start pulse while busy is high is ignored. The running transfer keeps its address and length, and no second transfer follows.
- R11: A flush while idle leaves fill_cnt at 0 and fill_full at 0 in the next cycle, and discards a word offered in the same cycle. A flush while busy has no effect on the FIFO contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| flush | input | 1 | Discards every FIFO word; honoured only while idle |
| snk_valid | input | 1 | Stream word present |
| snk_data | input | 32 | Stream word |
| snk_ready | output | 1 | Sink can take a word (FIFO not full) |
| cmd_start | input | 1 | Start pulse for a transfer |
| cmd_addr | input | 32 | Byte start address, word aligned |
| cmd_len | input | 16 | Transfer length in words |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| fill_cnt | output | 4 | FIFO level, wraps to 0 at DEPTH words |
| fill_full | output | 1 | FIFO holds DEPTH words |
| mem_addr | output | 32 | Write byte address |
| mem_write | output | 1 | Write request |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables, all ones |
| mem_waitreq | input | 1 | Slave stalls the current write |

## Verification
A stream push and a memory-side pop can land on the same clock edge. This is the case where a level counter that handles only one direction per cycle goes wrong. The bench provokes it by leaving two words in the FIFO and then starting a transfer while a word is streamed on every cycle and the slave accepts every write. The level is sampled after each edge and must stay constant at three words, and the written data must still come out in arrival order. A second overlap is a start pulse or a flush arriving while a write is stalled. Both are judged at the ports, from the unchanged address sequence, write count and fill level.

// File: rtl/smw_pkg.sv
package smw_pkg;
  typedef enum logic [0:0] {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } sq_state_e;

  localparam int unsigned SMW_WORD_BYTES = 4;
endpackage

// File: rtl/smw_rst_sync.sv
module smw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/smw_fifo.sv
module smw_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     push,
  input  logic [DATA_W-1:0]        push_data,
  input  logic                     pop,
  output logic [DATA_W-1:0]        head,
  output logic [$clog2(DEPTH)-1:0] cnt,
  output logic                     full,
  output logic                     empty,
  output logic                     ready
);
  localparam int unsigned CNT_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] LAST_LVL = CNT_W'(DEPTH - 1);

  logic [DATA_W-1:0] store_q [DEPTH];
  logic [CNT_W-1:0]  wp_q, wp_n, rp_q, rp_n, cnt_q, cnt_n;
  logic              full_q, full_n;
  logic              wr_en;

  assign wr_en = push && !clr;

  always_comb begin
    wp_n   = wp_q;
    rp_n   = rp_q;
    cnt_n  = cnt_q;
    full_n = full_q;
    if (clr) begin
      wp_n   = '0;
      rp_n   = '0;
      cnt_n  = '0;
      full_n = 1'b0;
    end else begin
      if (push) wp_n = wp_q + 1'b1;
      if (pop)  rp_n = rp_q + 1'b1;
      if (push && !pop) begin
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == LAST_LVL) full_n = 1'b1;
      end else if (pop && !push) begin
        cnt_n  = cnt_q - 1'b1;
        full_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      wp_q   <= wp_n;
      rp_q   <= rp_n;
      cnt_q  <= cnt_n;
      full_q <= full_n;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wp_q == CNT_W'(g))) store_q[g] <= push_data;
    end
  end

  assign head  = store_q[rp_q];
  assign cnt   = cnt_q;
  assign full  = full_q;
  assign empty = !full_q && (cnt_q == '0);
  assign ready = !full_q;
endmodule

// File: rtl/smw_seq.sv
module smw_seq
  import smw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              fifo_empty,
  input  logic              waitreq,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              pop,
  output logic              busy,
  output logic              done
);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(SMW_WORD_BYTES);
  localparam logic [LEN_W-1:0]  ONE_LEFT  = LEN_W'(1);

  sq_state_e         st_q, st_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [LEN_W-1:0]  rem_q, rem_n;
  logic              done_q, done_n;
  logic              accept;

  assign wr_req = (st_q == SQ_RUN) && !fifo_empty;
  assign accept = wr_req && !waitreq;

  always_comb begin
    st_n   = st_q;
    addr_n = addr_q;
    rem_n  = rem_q;
    done_n = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start) begin
          addr_n = start_addr;
          rem_n  = start_len;
          if (start_len == '0) done_n = 1'b1;
          else                 st_n   = SQ_RUN;
        end
      end
      SQ_RUN: begin
        if (accept) begin
          addr_n = addr_q + ADDR_STEP;
          rem_n  = rem_q - 1'b1;
          if (rem_q == ONE_LEFT) begin
            st_n   = SQ_IDLE;
            done_n = 1'b1;
          end
        end
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      addr_q <= addr_n;
      rem_q  <= rem_n;
      done_q <= done_n;
    end
  end

  assign wr_addr = addr_q;
  assign pop     = accept;
  assign busy    = (st_q == SQ_RUN);
  assign done    = done_q;
endmodule

// File: rtl/stm_wr_master.sv
module stm_wr_master #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     snk_valid,
  input  logic [DATA_W-1:0]        snk_data,
  output logic                     snk_ready,
  input  logic                     cmd_start,
  input  logic [ADDR_W-1:0]        cmd_addr,
  input  logic [LEN_W-1:0]         cmd_len,
  output logic                     busy,
  output logic                     done,
  output logic [$clog2(DEPTH)-1:0] fill_cnt,
  output logic                     fill_full,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic                     mem_write,
  output logic [DATA_W-1:0]        mem_wdata,
  output logic [DATA_W/8-1:0]      mem_be,
  input  logic                     mem_waitreq
);
  localparam int unsigned BE_W = DATA_W / 8;

  logic rst_i_n;
  logic push, pop, flush_en, fifo_empty, seq_busy;

  smw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign push     = snk_valid && snk_ready;
  assign flush_en = flush && !seq_busy;

  smw_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .clr       (flush_en),
    .push      (push),
    .push_data (snk_data),
    .pop       (pop),
    .head      (mem_wdata),
    .cnt       (fill_cnt),
    .full      (fill_full),
    .empty     (fifo_empty),
    .ready     (snk_ready)
  );

  smw_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .start      (cmd_start),
    .start_addr (cmd_addr),
    .start_len  (cmd_len),
    .fifo_empty (fifo_empty),
    .waitreq    (mem_waitreq),
    .wr_req     (mem_write),
    .wr_addr    (mem_addr),
    .pop        (pop),
    .busy       (seq_busy),
    .done       (done)
  );

  assign busy   = seq_busy;
  assign mem_be = {BE_W{1'b1}};
endmodule

// File: rtl/smw_chk.sv
module smw_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     flush,
  input logic                     snk_valid,
  input logic                     snk_ready,
  input logic                     busy,
  input logic                     done,
  input logic [$clog2(DEPTH)-1:0] fill_cnt,
  input logic                     fill_full,
  input logic [ADDR_W-1:0]        mem_addr,
  input logic                     mem_write,
  input logic [DATA_W-1:0]        mem_wdata,
  input logic                     mem_waitreq
);
  AST_FULL_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_full |-> (fill_cnt == '0)); // R3

  AST_LEVEL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_valid && snk_ready && mem_write && !mem_waitreq)
    |=> (fill_cnt == $past(fill_cnt)) && (fill_full == $past(fill_full))); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_write && !mem_waitreq) |=> (mem_addr == $past(mem_addr) + ADDR_W'(4))); // R6

  AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_write && mem_waitreq)
    |=> mem_write && $stable(mem_addr) && $stable(mem_wdata)); // R7

  AST_NO_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_write); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done); // R9

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !busy) |=> (fill_cnt == '0) && !fill_full); // R11
endmodule

bind stm_wr_master smw_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .snk_valid   (snk_valid),
  .snk_ready   (snk_ready),
  .busy        (busy),
  .done        (done),
  .fill_cnt    (fill_cnt),
  .fill_full   (fill_full),
  .mem_addr    (mem_addr),
  .mem_write   (mem_write),
  .mem_wdata   (mem_wdata),
  .mem_waitreq (mem_waitreq)
);

// File: tb/stm_wr_master_test.sv
`timescale 1ns/1ps
module stm_wr_master_test;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          flush, snk_valid, snk_ready, cmd_start, busy, done;
  logic [31:0]   snk_data, cmd_addr, mem_addr, mem_wdata;
  logic [15:0]   cmd_len;
  logic [CW-1:0] fill_cnt;
  logic          fill_full, mem_write, mem_waitreq;
  logic [3:0]    mem_be;

  int n_tests = 0;
  int n_fail  = 0;

  stm_wr_master #(.DATA_W(32), .DEPTH(DEPTH), .ADDR_W(32), .LEN_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .snk_valid(snk_valid),
    .snk_data(snk_data), .snk_ready(snk_ready), .cmd_start(cmd_start),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .busy(busy), .done(done),
    .fill_cnt(fill_cnt), .fill_full(fill_full), .mem_addr(mem_addr),
    .mem_write(mem_write), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_waitreq(mem_waitreq)
  );

  always #2.5 clk = ~clk;

  // slave model and monitors
  int          wr_n;
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  int          idle_wr, hold_err, done_cnt, done_wide, done_late;
  logic        prev_wait, prev_acc, prev_done;
  logic [31:0] prev_addr, prev_data;
  int          wait_mode;
  logic [7:0]  lfsr;
  longint      cyc;

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (wait_mode)
      0:       mem_waitreq <= 1'b0;
      1:       mem_waitreq <= 1'b1;
      default: mem_waitreq <= lfsr[0];
    endcase
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (mem_write && !busy) idle_wr <= idle_wr + 1;
      if (prev_wait && (!mem_write || mem_addr !== prev_addr || mem_wdata !== prev_data))
        hold_err <= hold_err + 1;
      if (done) begin
        done_cnt <= done_cnt + 1;
        if (prev_done) done_wide <= done_wide + 1;
        if (!prev_acc) done_late <= done_late + 1;
      end
      if (mem_write && !mem_waitreq && wr_n < 64) begin
        log_addr[wr_n] <= mem_addr;
        log_data[wr_n] <= mem_wdata;
        wr_n <= wr_n + 1;
      end
      prev_wait <= mem_write && mem_waitreq;
      prev_acc  <= mem_write && !mem_waitreq;
      prev_done <= done;
      prev_addr <= mem_addr;
      prev_data <= mem_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push_word(input logic [31:0] d);
    @(negedge clk); snk_valid = 1'b1; snk_data = d;
    @(negedge clk); snk_valid = 1'b0;
  endtask

  task automatic start_cmd(input logic [31:0] a, input logic [15:0] l);
    @(negedge clk); cmd_start = 1'b1; cmd_addr = a; cmd_len = l;
    @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic clear_log();
    @(negedge clk);
    wr_n = 0; done_cnt = 0; done_wide = 0; done_late = 0; idle_wr = 0; hold_err = 0;
  endtask

  task automatic wait_idle(input string req);
    int k;
    k = 0;
    @(negedge clk);
    while ((busy || done) && k < 3000) begin
      @(negedge clk);
      k++;
    end
    repeat (2) @(negedge clk);
    chk({req, " transfer ends"}, 32'(k < 3000), 32'd1);
  endtask

  task automatic chk_log(input string req, input int n, input logic [31:0] a0,
                         input logic [31:0] d0, input int split, input logic [31:0] d1);
    chk({req, " write count"}, 32'(wr_n), 32'(n));
    for (int i = 0; i < n && i < 64; i++) begin
      chk({req, " address"}, log_addr[i], a0 + 32'(4 * i));
      chk({req, " data"}, log_data[i], (i < split) ? d0 + 32'(i) : d1 + 32'(i - split));
    end
  endtask

  // R1: reset values
  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready", 32'(snk_ready), 32'd1);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 write", 32'(mem_write), 32'd0);
    chk("R1 fill", 32'(fill_cnt), 32'd0);
    chk("R1 full", 32'(fill_full), 32'd0);
  endtask

  // R1 R5 R6 R8 R9: words captured before start are written first
  task automatic t_prefill();
    clear_log();
    for (int i = 0; i < 5; i++) push_word(32'hA000_0000 + 32'(i));
    chk("R1 fill after idle pushes", 32'(fill_cnt), 32'd5);
    chk("R8 no write while idle", 32'(wr_n), 32'd0);
    start_cmd(32'h100, 16'd8);
    for (int i = 5; i < 8; i++) push_word(32'hA000_0000 + 32'(i));
    wait_idle("R9");
    chk_log("R5", 8, 32'h100, 32'hA000_0000, 8, 32'h0);
    chk("R6 byte enables", 32'(mem_be), 32'hF);
    chk("R9 one done", 32'(done_cnt), 32'd1);
    chk("R9 done width", 32'(done_wide), 32'd0);
    chk("R9 done after last write", 32'(done_late), 32'd0);
    chk("R8 idle writes", 32'(idle_wr), 32'd0);
    chk("R8 drained", 32'(fill_cnt), 32'd0);
  endtask

  // R2 R3: full wrap, rejected word, first pop
  task automatic t_full();
    clear_log();
    for (int i = 0; i < DEPTH; i++) push_word(32'hB000_0000 + 32'(i));
    chk("R3 wrapped count", 32'(fill_cnt), 32'd0);
    chk("R3 full flag", 32'(fill_full), 32'd1);
    chk("R2 ready low", 32'(snk_ready), 32'd0);
    @(negedge clk); snk_valid = 1'b1; snk_data = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    snk_valid = 1'b0;
    chk("R2 count unchanged", 32'(fill_cnt), 32'd0);
    chk("R2 still full", 32'(fill_full), 32'd1);
    start_cmd(32'h200, 16'd1);
    wait_idle("R3");
    chk("R3 level after pop", 32'(fill_cnt), 32'(DEPTH - 1));
    chk("R3 full cleared", 32'(fill_full), 32'd0);
    chk("R3 ready back", 32'(snk_ready), 32'd1);
    chk_log("R3", 1, 32'h200, 32'hB000_0000, 1, 32'h0);
    clear_log();
    start_cmd(32'h300, 16'(DEPTH - 1));
    wait_idle("R2");
    chk_log("R2", DEPTH - 1, 32'h300, 32'hB000_0001, DEPTH - 1, 32'h0);
    chk("R2 nothing left", 32'(fill_cnt), 32'd0);
  endtask

  // R4: push and pop on the same edge
  task automatic t_overlap();
    clear_log();
    push_word(32'hC000_0000);
    push_word(32'hC000_0001);
    @(negedge clk);
    cmd_start = 1'b1; cmd_addr = 32'h400; cmd_len = 16'd10;
    for (int i = 2; i < 10; i++) begin
      snk_valid = 1'b1; snk_data = 32'hC000_0000 + 32'(i);
      @(negedge clk);
      cmd_start = 1'b0;
      chk("R4 steady level", 32'(fill_cnt), 32'd3);
    end
    snk_valid = 1'b0;
    wait_idle("R4");
    chk_log("R4", 10, 32'h400, 32'hC000_0000, 10, 32'h0);
  endtask

  // R7 R8: random stalls while streaming
  task automatic t_stall();
    clear_log();
    wait_mode = 2;
    start_cmd(32'h500, 16'd20);
    for (int i = 0; i < 20; i++) push_word(32'hD000_0000 + 32'(i));
    wait_idle("R7");
    wait_mode = 0;
    chk("R7 held under wait", 32'(hold_err), 32'd0);
    chk("R8 idle writes", 32'(idle_wr), 32'd0);
    chk_log("R7", 20, 32'h500, 32'hD000_0000, 20, 32'h0);
  endtask

  // R10 R11: start and flush during a stalled write
  task automatic t_busy_ignore();
    clear_log();
    wait_mode = 1;
    push_word(32'hE000_0000);
    push_word(32'hE000_0001);
    start_cmd(32'h600, 16'd2);
    repeat (3) @(negedge clk);
    chk("R7 stalled write", 32'(mem_write), 32'd1);
    start_cmd(32'h700, 16'd5);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    chk("R11 flush while busy", 32'(fill_cnt), 32'd2);
    chk("R10 address kept", mem_addr, 32'h600);
    wait_mode = 0;
    wait_idle("R10");
    repeat (5) @(negedge clk);
    chk("R10 no second transfer", 32'(busy), 32'd0);
    chk_log("R10", 2, 32'h600, 32'hE000_0000, 2, 32'h0);
    chk("R10 one done", 32'(done_cnt), 32'd1);
  endtask

  // R9: zero length
  task automatic t_zero_len();
    clear_log();
    @(negedge clk); cmd_start = 1'b1; cmd_addr = 32'h900; cmd_len = 16'd0;
    @(posedge clk); #1;
    chk("R9 zero length done", 32'(done), 32'd1);
    chk("R9 zero length busy", 32'(busy), 32'd0);
    @(negedge clk); cmd_start = 1'b0;
    @(negedge clk);
    chk("R9 zero length pulse ends", 32'(done), 32'd0);
    chk("R9 zero length no write", 32'(wr_n), 32'd0);
  endtask

  // R11: idle flush discards old and concurrent words
  task automatic t_flush();
    clear_log();
    for (int i = 0; i < 3; i++) push_word(32'hF000_0000 + 32'(i));
    chk("R11 level before flush", 32'(fill_cnt), 32'd3);
    @(negedge clk); flush = 1'b1; snk_valid = 1'b1; snk_data = 32'hF0F0_F0F0;
    @(negedge clk); flush = 1'b0; snk_valid = 1'b0;
    chk("R11 flushed count", 32'(fill_cnt), 32'd0);
    chk("R11 flushed full", 32'(fill_full), 32'd0);
    push_word(32'h1234_5678);
    start_cmd(32'h800, 16'd1);
    wait_idle("R11");
    chk_log("R11", 1, 32'h800, 32'h1234_5678, 1, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; flush = 1'b0; snk_valid = 1'b0; snk_data = '0;
    cmd_start = 1'b0; cmd_addr = '0; cmd_len = '0;
    wait_mode = 0; lfsr = 8'h5A; cyc = 0; mem_waitreq = 1'b0;
    wr_n = 0; idle_wr = 0; hold_err = 0; done_cnt = 0; done_wide = 0; done_late = 0;
    prev_wait = 1'b0; prev_acc = 1'b0; prev_done = 1'b0; prev_addr = '0; prev_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_prefill();
    t_full();
    t_overlap();
    t_stall();
    t_busy_ignore();
    t_zero_len();
    t_flush();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule